// File: doc/BRIEF.md
# Multi-output clock divider bank

This block holds three integer dividers that all count cycles of one reference clock. Each divider drives a one-cycle clock-enable pulse on its own output, once per divided period. Software sets each divider's ratio through a small word-addressed register port. A new ratio does not take effect when it is written. The block records it as pending in a change-status register, and a later GO command applies every pending ratio in one operation.

Each divider has an align bit. A pending divider whose align bit is clear switches at its own next period boundary. Pending dividers whose align bit is set finish their current period and then wait. They all restart together, so their periods begin on the same reference edge.

The GO command is run by a four-state machine:
- `GO_IDLE` waits for a GO write. It moves to `GO_ARM` when the GO bit is written.
- `GO_ARM` captures the pending and align sets. It always moves on to `GO_RUN`.
- `GO_RUN` carries out the switches. It moves to `GO_DONE` once no divider is left pending.
- `GO_DONE` clears the change bits it captured. It always returns to `GO_IDLE`.

Top module: `clkdiv_bank`

## Requirements
- R1: A divider whose active ratio field is v and whose enable bit is set pulses `div_tick` for one cycle every v+1 reference cycles. A value of 0 keeps the output high on every cycle.
- R2: Register map, by byte address:
  - 0x00, 0x04 and 0x08 are the divider registers of dividers 0, 1 and 2.
  - 0x0C is the change-status register and 0x10 the align register.
  - 0x14 is the command register and 0x18 the status register.
  - Any other address reads 0.
- R3: Reset values:
  - The divider registers read 0x0000_8002, 0x0000_8004 and 0x0000_803F.
  - The change-status register reads 0, and the align register reads 0x92.
  - The status register reads 0, and the outputs start with those ratios.
- R4: Divider register fields:
  - The ratio field is bits 7:0, and bit 15 is a read/write enable.
  - Every other bit reads 0, and writes to those bits are ignored.
  - A disabled divider holds its output low. Once it is enabled again, its count restarts from zero.
- R5: A write to a divider register changes its output only when a later GO runs.
  - When the written ratio differs from the stored one, the divider's change bit is set. The change bits of dividers 0, 1 and 2 are bits 1, 4 and 7.
  - Rewriting the stored ratio leaves the change bits as they were.
- R6: The change-status register is read/write at bits 1, 4 and 7. Its other bits read 0.
- R7: GO start and busy flag:
  - Writing 1 to bit 0 of the command register while idle starts a GO.
  - Status bit 0 (busy) reads 1 from the next cycle until the GO ends. The command register always reads 0.
  - A GO write made while busy is ignored.
- R8: A GO leaves dividers whose change bit is clear undisturbed. Their pulse spacing does not change.
- R9: A pending divider whose align bit is clear loads its new ratio at its next terminal count and restarts from zero. An enabled divider gives no extra pulse, and a disabled one loads at once. The align bits of dividers 0, 1 and 2 are bits 1, 4 and 7.
- R10: Pending dividers whose align bit is set:
  - Each one pulses at its terminal count and then holds with its output low.
  - On the first edge at which all of them are held, they all load their new ratios and restart from zero together.
- R11: A ratio switch only ever happens at a period boundary. A period is never cut short.
- R12: GO completion:
  - The busy flag drops after the last switch, and the change bits captured at the start of the GO are cleared.
  - A GO with no change bit set keeps the busy flag high for exactly 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| div_tick | output | NUM_DIV | One-cycle clock-enable pulse of each divider |
| go_busy | output | 1 | High while a GO operation is in progress |

## Verification
A wrong active ratio or terminal compare shows at `div_tick` within one divided period, at most 256 reference cycles, as a pulse on the wrong cycle. A stuck or mis-captured pending set shows in one of two ways: either a divider switches when it should not, or `go_busy` never falls. A wrong hold or release of the aligned group shows in the cycles right after a GO, as aligned outputs whose pulses stop coinciding. A bench model that steps every cycle catches each of these on the first cycle that differs.

// File: rtl/clkdiv_bank_pkg.sv
package clkdiv_bank_pkg;

    typedef enum logic [1:0] {
        GO_IDLE = 2'd0,
        GO_ARM  = 2'd1,
        GO_RUN  = 2'd2,
        GO_DONE = 2'd3
    } go_state_e;

    // word indices (byte address / 4); dividers occupy words 0..NUM_DIV-1
    localparam int unsigned WIDX_CHG  = 3;
    localparam int unsigned WIDX_ALN  = 4;
    localparam int unsigned WIDX_CMD  = 5;
    localparam int unsigned WIDX_STAT = 6;

endpackage

// File: rtl/cdb_divider.sv
module cdb_divider #(
    parameter int               RATIO_W   = 8,
    parameter logic [RATIO_W-1:0] RST_RATIO = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] new_ratio,
    input  logic               load,
    input  logic               park_req,
    output logic               tick,
    output logic               parked,
    output logic [RATIO_W-1:0] act_ratio
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_q;
    logic               park_q;

    // terminal count of the running period
    assign tick      = en & ~park_q & (cnt_q == act_q);
    assign parked    = park_q;
    assign act_ratio = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= RST_RATIO;
            park_q <= 1'b0;
        end else if (load) begin
            act_q  <= new_ratio;
            cnt_q  <= '0;
            park_q <= 1'b0;
        end else if (park_req) begin
            park_q <= 1'b1;
        end else if (!park_q) begin
            if (!en || tick) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cdb_regs.sv
module cdb_regs
    import clkdiv_bank_pkg::*;
#(
    parameter int                        NUM_DIV    = 3,
    parameter int                        RATIO_W    = 8,
    parameter int                        DATA_W     = 32,
    parameter int                        ADDR_W     = 5,
    parameter int                        EN_BIT     = 15,
    parameter logic [NUM_DIV*RATIO_W-1:0] RST_RATIOS = {8'h3F, 8'h04, 8'h02},
    parameter logic [NUM_DIV*8-1:0]      SLOT_POS   = {8'd7, 8'd4, 8'd1}
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    input  logic                            busy,
    input  logic [NUM_DIV-1:0]              chg_clr,
    output logic [NUM_DIV-1:0][RATIO_W-1:0] cfg_ratio,
    output logic [NUM_DIV-1:0]              cfg_en,
    output logic [NUM_DIV-1:0]              chg_q,
    output logic [NUM_DIV-1:0]              aln_q,
    output logic                            go_req
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             wr_chg;
    logic             wr_aln;

    assign widx   = bus_addr[ADDR_W-1:2];
    assign wr_chg = bus_we && (widx == IDX_W'(WIDX_CHG));
    assign wr_aln = bus_we && (widx == IDX_W'(WIDX_ALN));
    assign go_req = bus_we && (widx == IDX_W'(WIDX_CMD)) && bus_wdata[0];

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_slot
        localparam int P = int'(SLOT_POS[g*8 +: 8]);

        logic               wr_div;
        logic [RATIO_W-1:0] ratio_r;
        logic               en_r;
        logic               chg_r;
        logic               chg_nxt;
        logic               aln_r;

        assign wr_div = bus_we && (widx == IDX_W'(g));

        always_comb begin
            chg_nxt = chg_r;
            if (wr_chg) begin
                chg_nxt = bus_wdata[P];
            end else if (wr_div && (bus_wdata[RATIO_W-1:0] != ratio_r)) begin
                chg_nxt = 1'b1;
            end
            if (chg_clr[g]) begin
                chg_nxt = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ratio_r <= RST_RATIOS[g*RATIO_W +: RATIO_W];
                en_r    <= 1'b1;
                chg_r   <= 1'b0;
                aln_r   <= 1'b1;
            end else begin
                if (wr_div) begin
                    ratio_r <= bus_wdata[RATIO_W-1:0];
                    en_r    <= bus_wdata[EN_BIT];
                end
                if (wr_aln) begin
                    aln_r <= bus_wdata[P];
                end
                chg_r <= chg_nxt;
            end
        end

        assign cfg_ratio[g] = ratio_r;
        assign cfg_en[g]    = en_r;
        assign chg_q[g]     = chg_r;
        assign aln_q[g]     = aln_r;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (widx == IDX_W'(i)) begin
                bus_rdata[RATIO_W-1:0] = cfg_ratio[i];
                bus_rdata[EN_BIT]      = cfg_en[i];
            end
            if (widx == IDX_W'(WIDX_CHG)) begin
                bus_rdata[int'(SLOT_POS[i*8 +: 8])] = chg_q[i];
            end
            if (widx == IDX_W'(WIDX_ALN)) begin
                bus_rdata[int'(SLOT_POS[i*8 +: 8])] = aln_q[i];
            end
        end
        if (widx == IDX_W'(WIDX_STAT)) begin
            bus_rdata[0] = busy;
        end
    end

endmodule

// File: rtl/cdb_go_fsm.sv
module cdb_go_fsm
    import clkdiv_bank_pkg::*;
#(
    parameter int NUM_DIV = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_req,
    input  logic [NUM_DIV-1:0] chg,
    input  logic [NUM_DIV-1:0] aln,
    input  logic [NUM_DIV-1:0] tick,
    input  logic [NUM_DIV-1:0] parked,
    input  logic [NUM_DIV-1:0] en,
    output logic               busy,
    output logic [NUM_DIV-1:0] load,
    output logic [NUM_DIV-1:0] park_req,
    output logic [NUM_DIV-1:0] chg_clr,
    output logic [NUM_DIV-1:0] captured
);

    go_state_e          state_q;
    go_state_e          state_d;
    logic [NUM_DIV-1:0] rem_imm_q;
    logic [NUM_DIV-1:0] rem_aln_q;
    logic [NUM_DIV-1:0] sel_q;
    logic               in_run;
    logic               release_grp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GO_IDLE: if (go_req) state_d = GO_ARM;
            GO_ARM:  state_d = GO_RUN;
            GO_RUN:  if ((rem_imm_q | rem_aln_q) == '0) state_d = GO_DONE;
            GO_DONE: state_d = GO_IDLE;
            default: state_d = GO_IDLE;
        endcase
    end

    always_comb begin
        in_run      = (state_q == GO_RUN);
        release_grp = in_run && (rem_aln_q != '0) && ((parked | ~rem_aln_q) == '1);
        busy        = (state_q != GO_IDLE);
        chg_clr     = (state_q == GO_DONE) ? sel_q : '0;
        captured    = sel_q;
        for (int i = 0; i < NUM_DIV; i++) begin
            load[i]     = in_run && ((rem_imm_q[i] && (tick[i] || !en[i]))
                                     || (rem_aln_q[i] && release_grp));
            park_req[i] = in_run && rem_aln_q[i] && !parked[i]
                          && (tick[i] || !en[i]) && !release_grp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_imm_q <= '0;
            rem_aln_q <= '0;
            sel_q     <= '0;
        end else if (state_q == GO_ARM) begin
            rem_imm_q <= chg & ~aln;
            rem_aln_q <= chg & aln;
            sel_q     <= chg;
        end else if (state_q == GO_RUN) begin
            rem_imm_q <= rem_imm_q & ~load;
            rem_aln_q <= rem_aln_q & ~load;
        end
    end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
    parameter int                        NUM_DIV    = 3,
    parameter int                        RATIO_W    = 8,
    parameter int                        DATA_W     = 32,
    parameter int                        ADDR_W     = 5,
    parameter int                        EN_BIT     = 15,
    parameter logic [NUM_DIV*RATIO_W-1:0] RST_RATIOS = {8'h3F, 8'h04, 8'h02},
    parameter logic [NUM_DIV*8-1:0]      SLOT_POS   = {8'd7, 8'd4, 8'd1}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_DIV-1:0]  div_tick,
    output logic                go_busy
);

    logic [NUM_DIV-1:0][RATIO_W-1:0] cfg_ratio;
    logic [NUM_DIV-1:0][RATIO_W-1:0] act_ratio;
    logic [NUM_DIV-1:0]              cfg_en;
    logic [NUM_DIV-1:0]              chg_q;
    logic [NUM_DIV-1:0]              aln_q;
    logic [NUM_DIV-1:0]              chg_clr;
    logic [NUM_DIV-1:0]              captured;
    logic [NUM_DIV-1:0]              load_v;
    logic [NUM_DIV-1:0]              park_v;
    logic [NUM_DIV-1:0]              parked_v;
    logic [NUM_DIV-1:0]              tick_v;
    logic                            go_req;
    logic                            busy;

    cdb_regs #(
        .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .EN_BIT(EN_BIT), .RST_RATIOS(RST_RATIOS), .SLOT_POS(SLOT_POS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .chg_clr(chg_clr), .cfg_ratio(cfg_ratio), .cfg_en(cfg_en),
        .chg_q(chg_q), .aln_q(aln_q), .go_req(go_req)
    );

    cdb_go_fsm #(.NUM_DIV(NUM_DIV)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .chg(chg_q), .aln(aln_q),
        .tick(tick_v), .parked(parked_v), .en(cfg_en), .busy(busy),
        .load(load_v), .park_req(park_v), .chg_clr(chg_clr), .captured(captured)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        cdb_divider #(
            .RATIO_W(RATIO_W),
            .RST_RATIO(RST_RATIOS[g*RATIO_W +: RATIO_W])
        ) u_div (
            .clk(clk), .rst_n(rst_n), .en(cfg_en[g]), .new_ratio(cfg_ratio[g]),
            .load(load_v[g]), .park_req(park_v[g]), .tick(tick_v[g]),
            .parked(parked_v[g]), .act_ratio(act_ratio[g])
        );
    end

    assign div_tick = tick_v;
    assign go_busy  = busy;

endmodule

// File: rtl/cdb_checker.sv
module cdb_checker
    import clkdiv_bank_pkg::*;
#(
    parameter int NUM_DIV = 3,
    parameter int RATIO_W = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_we,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_wdata,
    input logic [NUM_DIV-1:0]              div_tick,
    input logic                            go_busy,
    input logic [NUM_DIV-1:0]              en,
    input logic [NUM_DIV-1:0]              chg,
    input logic [NUM_DIV-1:0]              sel,
    input logic [NUM_DIV-1:0]              load,
    input logic [NUM_DIV-1:0]              parked,
    input logic [NUM_DIV-1:0][RATIO_W-1:0] act
);

    logic go_wr;
    assign go_wr = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(WIDX_CMD)) && bus_wdata[0];

    AST_BUSY_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_busy) |-> $past(go_wr)); // R7

    AST_CHG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go_busy) |-> ((chg & $past(sel)) == '0)); // R12

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_chk
        logic [RATIO_W:0] gap_q;
        logic             valid_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gap_q   <= '0;
                valid_q <= 1'b0;
            end else begin
                if (div_tick[g]) begin
                    gap_q <= '0;
                end else if (gap_q != '1) begin
                    gap_q <= gap_q + 1'b1;
                end
                if (go_busy || !en[g]) begin
                    valid_q <= 1'b0;
                end else if (div_tick[g]) begin
                    valid_q <= 1'b1;
                end
            end
        end

        AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
            (div_tick[g] && valid_q && !go_busy && en[g]) |-> (gap_q == {1'b0, act[g]})); // R1

        AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
            load[g] |-> (div_tick[g] || !en[g] || parked[g])); // R11

        AST_ALIGN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(parked[g]) |-> (parked == '0)); // R10
    end

endmodule

bind clkdiv_bank cdb_checker #(
    .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .div_tick(div_tick), .go_busy(go_busy),
    .en(cfg_en), .chg(chg_q), .sel(captured), .load(load_v),
    .parked(parked_v), .act(act_ratio)
);

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  div_tick;
    logic        go_busy;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    clkdiv_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_tick(div_tick),
        .go_busy(go_busy)
    );

    // ---------------- behavioural reference model ----------------
    int POS[N] = '{1, 4, 7};
    int RST[N] = '{2, 4, 63};
    int m_ratio[N], m_act[N], m_cnt[N];
    bit m_en[N], m_park[N], m_chg[N], m_aln[N], m_rimm[N], m_raln[N], m_sel[N];
    int m_st; // 0 idle, 1 arm, 2 run, 3 done

    function automatic bit m_tick(int i);
        return m_en[i] && !m_park[i] && (m_cnt[i] == m_act[i]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_ratio[i] = RST[i]; m_act[i] = RST[i]; m_cnt[i] = 0;
                m_en[i] = 1; m_park[i] = 0; m_chg[i] = 0; m_aln[i] = 1;
                m_rimm[i] = 0; m_raln[i] = 0; m_sel[i] = 0;
            end
            m_st = 0;
        end else begin
            bit t[N];
            bit allp, anya, pend, rel;
            int widx;
            allp = 1; anya = 0; pend = 0;
            for (int i = 0; i < N; i++) begin
                t[i] = m_tick(i);
                if (m_raln[i]) begin anya = 1; if (!m_park[i]) allp = 0; end
                if (m_rimm[i] || m_raln[i]) pend = 1;
            end
            rel = (m_st == 2) && anya && allp;
            for (int i = 0; i < N; i++) begin
                if (m_st == 2 && m_rimm[i] && (t[i] || !m_en[i])) begin
                    m_act[i] = m_ratio[i]; m_cnt[i] = 0; m_rimm[i] = 0;
                end else if (m_st == 2 && m_raln[i] && rel) begin
                    m_act[i] = m_ratio[i]; m_cnt[i] = 0; m_park[i] = 0; m_raln[i] = 0;
                end else if (m_st == 2 && m_raln[i] && !m_park[i] && (t[i] || !m_en[i])) begin
                    m_park[i] = 1;
                end else if (!m_park[i]) begin
                    if (!m_en[i] || t[i]) m_cnt[i] = 0;
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (m_st == 1) begin
                for (int i = 0; i < N; i++) begin
                    m_rimm[i] = m_chg[i] && !m_aln[i];
                    m_raln[i] = m_chg[i] && m_aln[i];
                    m_sel[i]  = m_chg[i];
                end
            end
            widx = int'(bus_addr) / 4;
            if (bus_we) begin
                if (widx < N) begin
                    if (int'(bus_wdata[7:0]) != m_ratio[widx]) m_chg[widx] = 1;
                    m_ratio[widx] = int'(bus_wdata[7:0]);
                    m_en[widx]    = bus_wdata[15];
                end else if (widx == 3) begin
                    for (int i = 0; i < N; i++) m_chg[i] = bus_wdata[POS[i]];
                end else if (widx == 4) begin
                    for (int i = 0; i < N; i++) m_aln[i] = bus_wdata[POS[i]];
                end
            end
            if (m_st == 3) begin
                for (int i = 0; i < N; i++) if (m_sel[i]) m_chg[i] = 0;
            end
            case (m_st)
                0: if (bus_we && widx == 5 && bus_wdata[0]) m_st = 1;
                1: m_st = 2;
                2: if (!pend) m_st = 3;
                default: m_st = 0;
            endcase
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                checks++;
                if (div_tick[i] !== m_tick(i)) begin
                    errors++;
                    $display("FAIL R1 R8 R9 R10 R11 tick[%0d] at %0t: got %0b expected %0b",
                             i, $time, div_tick[i], m_tick(i));
                end
            end
            checks++;
            if (go_busy !== (m_st != 0)) begin
                errors++;
                $display("FAIL R7 R12 go_busy at %0t: got %0b expected %0b",
                         $time, go_busy, (m_st != 0));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && go_busy; k++) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] d;
        int n;
        bus_we = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state; R2: map
        rd(5'h00, d); check("R3 div0 reset", d, 32'h0000_8002);
        rd(5'h04, d); check("R3 div1 reset", d, 32'h0000_8004);
        rd(5'h08, d); check("R3 div2 reset", d, 32'h0000_803F);
        rd(5'h0C, d); check("R3 chg reset", d, 32'h0);
        rd(5'h10, d); check("R3 align reset", d, 32'h92);
        rd(5'h18, d); check("R3 stat reset", d, 32'h0);
        rd(5'h14, d); check("R7 cmd reads 0", d, 32'h0);
        rd(5'h1C, d); check("R2 unmapped reads 0", d, 32'h0);

        repeat (150) @(negedge clk); // R1 periods checked by model

        // R5: deferred write and change flag
        wr(5'h04, 32'h0000_8004);
        rd(5'h0C, d); check("R5 same ratio no flag", d, 32'h0);
        wr(5'h00, 32'h0000_8005);
        rd(5'h0C, d); check("R5 new ratio flags bit1", d, 32'h02);
        rd(5'h00, d); check("R5 div0 readback", d, 32'h0000_8005);
        repeat (20) @(negedge clk);

        // R6: change register read/write
        wr(5'h0C, 32'h0000_0090);
        rd(5'h0C, d); check("R6 chg write", d, 32'h90);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, d); check("R6 chg only slots", d, 32'h92);
        wr(5'h0C, 32'h0000_0002);

        // R4: reserved bits, enable off
        wr(5'h08, 32'hFFFF_7F3F);
        rd(5'h08, d); check("R4 reserved bits zero, enable clear", d, 32'h0000_003F);
        rd(5'h0C, d); check("R4 same ratio keeps chg", d, 32'h02);
        n = 0;
        for (int k = 0; k < 100; k++) begin @(negedge clk); if (div_tick[2]) n++; end
        check("R4 disabled output low", n, 0);
        wr(5'h08, 32'h0000_803F);

        // R9 immediate switch of div0, R7 busy, ignored second GO
        wr(5'h10, 32'h0000_0090);
        wr(5'h14, 32'h1);
        rd(5'h18, d); check("R7 busy set", d, 32'h1);
        wr(5'h14, 32'h1);
        wait_idle();
        repeat (3) @(negedge clk);
        check("R7 ignored GO while busy", go_busy, 0);
        rd(5'h0C, d); check("R12 chg cleared", d, 32'h0);

        // R10 aligned pair
        wr(5'h04, 32'h0000_8002);
        wr(5'h08, 32'h0000_8002);
        rd(5'h0C, d); check("R5 two flags", d, 32'h90);
        wr(5'h10, 32'h0000_0092);
        wr(5'h14, 32'h1);
        wait_idle();
        n = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (div_tick[1] != div_tick[2]) n++; end
        check("R10 aligned pulses coincide", n, 0);
        rd(5'h0C, d); check("R12 chg cleared after aligned GO", d, 32'h0);

        // R8 unflagged divider undisturbed
        wr(5'h08, 32'h0000_8009);
        wr(5'h14, 32'h1);
        n = 0;
        for (int k = 0; k < 60; k++) begin @(negedge clk); if (div_tick[0]) n++; end
        check("R8 div0 keeps spacing", n, 10);
        wait_idle();

        // R12 empty GO lasts 3 cycles
        wr(5'h14, 32'h1);
        n = 0;
        for (int k = 0; k < 10 && go_busy; k++) begin n++; @(negedge clk); end
        check("R12 empty GO length", n, 3);

        // R1 divide by one
        wr(5'h00, 32'h0000_8000);
        wr(5'h14, 32'h1);
        wait_idle();
        n = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (div_tick[0]) n++; end
        check("R1 ratio 0 steady high", n, 20);

        repeat (20) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule